// File: doc/BRIEF.md
# Multi-Mode Serial Flash Read Sequencer

This block is the master side of a read from a serial NOR flash. A request gives a 4-bit mode code, a 24-bit start address and a byte count. The block then runs one chip-select window on the serial bus. It sends an 8-bit opcode on one lane and the address on one, two or four lanes. Next come the dummy clocks, with the lanes released. Last, it collects the data on one, two or four lanes and hands each byte to the consumer on a one-cycle valid strobe.

The mode code is sampled when the request is accepted. A table indexed by it sets the opcode, the number of dummy bytes, the address and data lane widths, and the serial-clock half period. Codes with no table entry are refused with a one-cycle error pulse. A zero byte count is refused the same way.

The lanes are split into output, output-enable and input vectors, so the pad ring can build the tristate buffers.

Top module: `spi_flash_rd_seq`

## Requirements
- R1: Each mode code sets opcode / dummy bytes / address lanes / data lanes / half period in system cycles: 0x4 = 0x0B/1/1/1/2, 0x5 = 0x03/0/1/1/3, 0x6 = 0x0B/1/1/2/1, 0x7 = 0x1B/2/1/2/1, 0x8 = 0x3B/1/1/2/2, 0x9 = 0xBB/1/2/2/2, 0xA and 0xC = 0x6B/1/1/4/2, 0xB, 0xD and 0xE = 0xEB/3/4/4/2.
- R2: The opcode is sent most significant bit first on lane 0, and only lane 0 is enabled during the command phase.
- R3: The 24-bit address is sent MSB first on 1, 2 or 4 lanes, using lane 0, lanes 1..0 or lanes 3..0. Within each group, the highest enabled lane carries the highest bit.
- R4: Each dummy byte lasts 8 serial clocks whatever the lane width. All output enables are low from the first dummy clock until the transfer ends.
- R5: Data is sampled at the serial rising edge: on lane 1 for single width, on lanes 1..0 for dual and on lanes 3..0 for quad, with the higher lane carrying the higher bit and bytes filled MSB first. Each byte appears on `byte_o` with `byte_vld_o` high for exactly one cycle, in address order, once per requested byte.
- R6: The serial clock idles low and each half period lasts the mode's half-period count of system cycles. Chip select falls in the cycle after an accepted start and stays low for one serial period before the first rising edge. It stays low for exactly 2·H·(1 + 8 + 24/AW + 8·DB + 8·LEN/DW) system cycles, where H is the half period, AW and DW are the address and data lane widths, DB is the dummy byte count and LEN is the byte count.
- R7: Chip select rises right after the last data bit. `busy_o` falls one cycle later, and `done_o` pulses for one cycle as `busy_o` falls.
- R8: A start with mode 0x0–0x3 or 0xF, or with zero length, gives an `err_o` pulse in the next cycle. No transfer begins: chip select stays high and `busy_o` stays low.
- R9: A start while busy is ignored. Mode, address and length are captured only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Read mode code |
| addr_i | input | 24 | Flash start address |
| len_i | input | LEN_W | Byte count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | One-cycle pulse on a refused request |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | `byte_o` valid strobe |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
A slot counter or phase state that is off by one changes the length of the chip-select window. The bench counts that window cycle for cycle on every transfer, and the error shows in the very transfer where it happens. A wrong shift width or lane order in the address path corrupts the address the flash model decodes. The first received byte then differs from the expected memory content. A capture-side fault shows as wrong data bytes, a wrong byte count or a doubled valid strobe within the first byte period of the data phase. A fault in request screening shows as a missing error pulse, or as chip-select activity, within a few cycles of the refused start.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int HALF_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_END
  } rd_state_e;

  typedef struct packed {
    logic [7:0]        opc;
    logic [1:0]        dmy;
    logic [2:0]        aw;
    logic [2:0]        dw;
    logic [HALF_W-1:0] half;
  } mode_cfg_t;

  function automatic logic mode_ok(input logic [3:0] m);
    return (m >= 4'h4) && (m != 4'hF);
  endfunction

  function automatic mode_cfg_t mode_lookup(input logic [3:0] m);
    mode_cfg_t c;
    c = '{opc: 8'h0B, dmy: 2'd1, aw: 3'd1, dw: 3'd1, half: 2'd2};
    case (m)
      4'h5: c = '{opc: 8'h03, dmy: 2'd0, aw: 3'd1, dw: 3'd1, half: 2'd3};
      4'h6: c = '{opc: 8'h0B, dmy: 2'd1, aw: 3'd1, dw: 3'd2, half: 2'd1};
      4'h7: c = '{opc: 8'h1B, dmy: 2'd2, aw: 3'd1, dw: 3'd2, half: 2'd1};
      4'h8: c = '{opc: 8'h3B, dmy: 2'd1, aw: 3'd1, dw: 3'd2, half: 2'd2};
      4'h9: c = '{opc: 8'hBB, dmy: 2'd1, aw: 3'd2, dw: 3'd2, half: 2'd2};
      4'hA, 4'hC: c = '{opc: 8'h6B, dmy: 2'd1, aw: 3'd1, dw: 3'd4, half: 2'd2};
      4'hB, 4'hD, 4'hE: c = '{opc: 8'hEB, dmy: 2'd3, aw: 3'd4, dw: 3'd4, half: 2'd2};
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/spi_rd_mode_dec.sv
module spi_rd_mode_dec
  import spi_rd_pkg::*;
(
  input  logic [3:0] mode_i,
  output mode_cfg_t  cfg_o,
  output logic       ok_o
);
  assign cfg_o = mode_lookup(mode_i);
  assign ok_o  = mode_ok(mode_i);
endmodule

// File: rtl/spi_rd_halfgen.sv
module spi_rd_halfgen #(
  parameter int HW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW-1:0] half_i,
  output logic          tick_o,
  output logic          phase_o
);
  localparam logic [HW-1:0] ONE = HW'(1);
  logic [HW-1:0] cnt_q;
  logic          ph_q;

  assign tick_o  = run_i && (cnt_q == half_i - ONE);
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick_o) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/spi_rd_deser.sv
module spi_rd_deser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       cap_i,
  input  logic [2:0] lanes_i,
  input  logic [3:0] io_i,
  output logic [7:0] byte_o,
  output logic       vld_o
);
  logic [7:0] sr_q, sr_d, byte_q;
  logic [3:0] bc_q, bc_d;
  logic       vld_q;

  always_comb begin
    case (lanes_i)
      3'd4:    sr_d = {sr_q[3:0], io_i};
      3'd2:    sr_d = {sr_q[5:0], io_i[1:0]};
      default: sr_d = {sr_q[6:0], io_i[1]};
    endcase
    bc_d = bc_q + {1'b0, lanes_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; byte_q <= '0; bc_q <= '0; vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clr_i) begin
        bc_q <= '0;
      end else if (cap_i) begin
        sr_q <= sr_d;
        if (bc_d == 4'd8) begin
          byte_q <= sr_d;
          vld_q  <= 1'b1;
          bc_q   <= '0;
        end else begin
          bc_q <= bc_d;
        end
      end
    end
  end

  assign byte_o = byte_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/spi_flash_rd_seq.sv
module spi_flash_rd_seq
  import spi_rd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       mode_i,
  input  logic [23:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);
  localparam int CNT_W = LEN_W + 3;
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);

  rd_state_e        state_q;
  mode_cfg_t        cfg_in, cfg_q;
  logic             ok_in;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      sr_q;
  logic [CNT_W-1:0] cnt_q, addr_last, dmy_last, data_last;
  logic             run, tick, ph, rise, slot_end, err_q, done_q;

  spi_rd_mode_dec u_dec (.mode_i(mode_i), .cfg_o(cfg_in), .ok_o(ok_in));

  assign run = (state_q != ST_IDLE) && (state_q != ST_END);

  spi_rd_halfgen #(.HW(HALF_W)) u_half (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .half_i(cfg_q.half),
    .tick_o(tick), .phase_o(ph)
  );

  assign rise     = tick && !ph;
  assign slot_end = tick && ph;

  spi_rd_deser u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(state_q == ST_IDLE),
    .cap_i(rise && (state_q == ST_DATA)), .lanes_i(cfg_q.dw), .io_i(io_i),
    .byte_o(byte_o), .vld_o(byte_vld_o)
  );

  always_comb begin
    case (cfg_q.aw)
      3'd4:    addr_last = CNT_W'(5);
      3'd2:    addr_last = CNT_W'(11);
      default: addr_last = CNT_W'(23);
    endcase
    dmy_last = CNT_W'({cfg_q.dmy, 3'b000}) - C1;
    case (cfg_q.dw)
      3'd4:    data_last = CNT_W'({len_q, 1'b0}) - C1;
      3'd2:    data_last = CNT_W'({len_q, 2'b00}) - C1;
      default: data_last = CNT_W'({len_q, 3'b000}) - C1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '{opc: 8'h00, dmy: 2'd0, aw: 3'd1, dw: 3'd1, half: 2'd1};
      len_q   <= '0;
      sr_q    <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (ok_in && (len_i != '0)) begin
            cfg_q   <= cfg_in;
            len_q   <= len_i;
            sr_q    <= {cfg_in.opc, addr_i};
            state_q <= ST_LEAD;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_LEAD: if (slot_end) begin
          state_q <= ST_CMD;
          cnt_q   <= CNT_W'(7);
        end
        ST_CMD: if (slot_end) begin
          sr_q <= sr_q << 1;
          if (cnt_q == '0) begin
            state_q <= ST_ADDR;
            cnt_q   <= addr_last;
          end else cnt_q <= cnt_q - C1;
        end
        ST_ADDR: if (slot_end) begin
          sr_q <= sr_q << cfg_q.aw;
          if (cnt_q == '0) begin
            if (cfg_q.dmy == 2'd0) begin
              state_q <= ST_DATA;
              cnt_q   <= data_last;
            end else begin
              state_q <= ST_DUMMY;
              cnt_q   <= dmy_last;
            end
          end else cnt_q <= cnt_q - C1;
        end
        ST_DUMMY: if (slot_end) begin
          if (cnt_q == '0) begin
            state_q <= ST_DATA;
            cnt_q   <= data_last;
          end else cnt_q <= cnt_q - C1;
        end
        ST_DATA: if (slot_end) begin
          if (cnt_q == '0) state_q <= ST_END;
          else cnt_q <= cnt_q - C1;
        end
        default: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    io_o    = 4'b0000;
    io_oe_o = 4'b0000;
    if (state_q == ST_LEAD || state_q == ST_CMD) begin
      io_o    = {3'b000, sr_q[31]};
      io_oe_o = 4'b0001;
    end else if (state_q == ST_ADDR) begin
      case (cfg_q.aw)
        3'd4:    begin io_o = sr_q[31:28];            io_oe_o = 4'b1111; end
        3'd2:    begin io_o = {2'b00, sr_q[31:30]};   io_oe_o = 4'b0011; end
        default: begin io_o = {3'b000, sr_q[31]};     io_oe_o = 4'b0001; end
      endcase
    end
  end

  assign sck_o  = ph && run && (state_q != ST_LEAD);
  assign cs_no  = !run;
  assign busy_o = state_q != ST_IDLE;
  assign err_o  = err_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_rd_chk.sv
module spi_rd_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [3:0]       mode_i,
  input logic [LEN_W-1:0] len_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             byte_vld_o,
  input logic             sck_o,
  input logic             cs_no,
  input logic [3:0]       io_oe_o
);
  logic bad_req;
  assign bad_req = (mode_i < 4'h4) || (mode_i == 4'hF) || (len_i == '0);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o); // R6
  AST_LEAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sck_o); // R6
  AST_START_SELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !bad_req) |=> (busy_o && !cs_no)); // R6
  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no); // R7
  AST_DONE_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && cs_no)); // R7
  AST_BAD_REQ_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bad_req) |=> (err_o && !busy_o && cs_no)); // R8
  AST_BUSY_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !err_o); // R9
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o); // R5
  AST_RX_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> (io_oe_o == 4'b0000)); // R4
endmodule

bind spi_flash_rd_seq spi_rd_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/spi_flash_rd_seq_tb.sv
module spi_flash_rd_seq_tb;
  localparam int LEN_W = 16;

  typedef struct {
    logic [7:0] opc;
    int dmy, aw, dw, half;
  } exp_cfg_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = 4'h0;
  logic [23:0] addr = '0;
  logic [LEN_W-1:0] len = '0;
  logic busy, done, err, vld, sck, cs_n;
  logic [7:0] rbyte;
  logic [3:0] io_out, io_oe, io_in;

  always #10 clk = ~clk;

  spi_flash_rd_seq #(.LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .addr_i(addr),
    .len_i(len), .busy_o(busy), .done_o(done), .err_o(err), .byte_o(rbyte),
    .byte_vld_o(vld), .sck_o(sck), .cs_no(cs_n), .io_o(io_out), .io_oe_o(io_oe),
    .io_i(io_in)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_cfg_t cfg_of(input logic [3:0] m);
    exp_cfg_t c;
    case (m)
      4'h4: c = '{8'h0B, 1, 1, 1, 2};
      4'h5: c = '{8'h03, 0, 1, 1, 3};
      4'h6: c = '{8'h0B, 1, 1, 2, 1};
      4'h7: c = '{8'h1B, 2, 1, 2, 1};
      4'h8: c = '{8'h3B, 1, 1, 2, 2};
      4'h9: c = '{8'hBB, 1, 2, 2, 2};
      4'hA, 4'hC: c = '{8'h6B, 1, 1, 4, 2};
      default: c = '{8'hEB, 3, 4, 4, 2};
    endcase
    return c;
  endfunction

  function automatic logic [7:0] mem_at(input logic [23:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd7;
    return t ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // flash model
  exp_cfg_t fc;
  int ris = 0, oe_bad = 0;
  logic [7:0] cmd_rx;
  logic [23:0] addr_rx;
  logic [3:0] drv = 4'b0000;
  assign io_in = drv;

  always @(negedge cs_n) begin ris = 0; drv = 4'b0000; end

  always @(posedge sck) begin
    if (ris < 8) begin
      cmd_rx = {cmd_rx[6:0], io_out[0]};
      if (io_oe !== 4'b0001) oe_bad++;
    end else if (ris < 8 + 24 / fc.aw) begin
      case (fc.aw)
        4: begin addr_rx = {addr_rx[19:0], io_out};      if (io_oe !== 4'b1111) oe_bad++; end
        2: begin addr_rx = {addr_rx[21:0], io_out[1:0]}; if (io_oe !== 4'b0011) oe_bad++; end
        default: begin addr_rx = {addr_rx[22:0], io_out[0]}; if (io_oe !== 4'b0001) oe_bad++; end
      endcase
    end else if (io_oe !== 4'b0000) oe_bad++;
    ris++;
  end

  always @(negedge sck) begin
    int p, k, off;
    logic [7:0] b;
    p = 8 + 24 / fc.aw + 8 * fc.dmy;
    if (!cs_n && ris >= p) begin
      k   = ris - p;
      off = (k * fc.dw) % 8;
      b   = mem_at(addr_rx + 24'((k * fc.dw) / 8));
      case (fc.dw)
        4: drv = b[7-off -: 4];
        2: drv = {2'b00, b[7-off -: 2]};
        default: drv = {2'b00, b[7-off], 1'b0};
      endcase
    end
  end

  // monitor
  int cs_cnt = 0, done_cnt = 0, err_cnt = 0, nrx = 0, sck_bad = 0;
  logic [7:0] rx_q [0:63];
  always @(negedge clk) begin
    if (!cs_n) cs_cnt++;
    if (cs_n && sck) sck_bad++;
    if (done) done_cnt++;
    if (err) err_cnt++;
    if (vld) begin
      if (nrx < 64) rx_q[nrx] = rbyte;
      nrx++;
    end
  end

  task automatic clr_mon();
    cs_cnt = 0; done_cnt = 0; err_cnt = 0; nrx = 0; oe_bad = 0; sck_bad = 0;
  endtask

  task automatic xfer(input logic [3:0] m, input logic [23:0] a, input int l,
                      input bit poke);
    exp_cfg_t c;
    int t, slots;
    c = cfg_of(m);
    fc = c;
    clr_mon();
    @(negedge clk);
    start = 1'b1; mode = m; addr = a; len = LEN_W'(l);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; mode = 4'h5; addr = ~a; len = 16'd3;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    slots = 1 + 8 + 24 / c.aw + 8 * c.dmy + (8 * l) / c.dw;
    chk(cmd_rx == c.opc, "R1", "opcode", cmd_rx, c.opc);
    chk(addr_rx == a, "R3", "address", addr_rx, a);
    chk(oe_bad == 0, "R2", "lane enables per phase (R4)", oe_bad, 0);
    chk(cs_cnt == 2 * c.half * slots, "R6", "cs low cycles", cs_cnt, 2 * c.half * slots);
    chk(sck_bad == 0, "R6", "sck high while deselected", sck_bad, 0);
    chk(done_cnt == 1 && !busy && cs_n, "R7", "done pulses", done_cnt, 1);
    chk(err_cnt == 0, poke ? "R9" : "R8", "err pulses", err_cnt, 0);
    chk(nrx == l, "R5", "byte count", nrx, l);
    for (int i = 0; i < l && i < nrx && i < 64; i++)
      chk(rx_q[i] == mem_at(a + 24'(i)), "R5", $sformatf("byte %0d", i),
          rx_q[i], mem_at(a + 24'(i)));
  endtask

  task automatic refuse(input logic [3:0] m, input int l);
    clr_mon();
    @(negedge clk);
    start = 1'b1; mode = m; addr = 24'h123456; len = LEN_W'(l);
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(err_cnt == 1, "R8", $sformatf("err for mode %0h len %0d", m, l), err_cnt, 1);
    chk(cs_cnt == 0 && !busy, "R8", "no transfer", cs_cnt, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] m;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !busy && io_oe == 4'b0 && !vld, "R6", "reset state",
        {cs_n, sck, busy, io_oe, vld}, 8'h80);
    rst_n = 1'b1;
    // directed: every mode code once
    for (int mm = 4; mm < 15; mm++) xfer(4'(mm), 24'h00_10_00 + 24'(mm * 77), 2, 1'b0);
    // boundaries: single byte, address wrap
    xfer(4'h5, 24'hFFFFFF, 1, 1'b0);
    xfer(4'hE, 24'hFFFFFE, 4, 1'b0);
    // start while busy
    xfer(4'h7, 24'hABCDEF, 3, 1'b1);
    xfer(4'h4, 24'h000000, 2, 1'b1);
    // refused requests
    for (int mm = 0; mm < 4; mm++) refuse(4'(mm), 2);
    refuse(4'hF, 2);
    refuse(4'h9, 0);
    // random
    for (int i = 0; i < 30; i++) begin
      m = 4'(4 + ($urandom % 11));
      xfer(m, 24'($urandom), 1 + int'($urandom % 6), 1'b0);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule